// File: doc/BRIEF.md
# Interleaved Chroma Sample Sequencer

This block shares one sample converter between luminance and colour-difference samples. On every sample clock it reports which kind of sample the converter takes: a video sample, a chroma U sample or a chroma V sample. It also drives matching write strobes for the video memory, the U store and the V store, and a strobe that marks when a subcarrier-phase sample should be taken.

The slots follow a 13-slot cycle: eleven video slots, then one U slot, then one V slot. Each new line starts one position further into that cycle, so the chroma slots do not line up vertically. After thirteen lines the arrangement comes back to where it began, and by then every horizontal position has been sampled in every slot type.

The video strobe is held low on the U and V slots, so chroma never reaches video memory. The inputs are a line-start strobe and a field-start strobe. All pins are plain control pins. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `ilv_slot_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `slot_idx` and `line_idx` are 0, `slot_code` is 2'b00 (video), `video_we` is 1 and the other three strobes are 0.
- R2: With no strobe present, `slot_idx` rises by one on each clock and goes from 12 back to 0.
- R3: `slot_code` is 2'b00 (video) for slot indices 0 to 10, 2'b01 (chroma U) for index 11 and 2'b10 (chroma V) for index 12.
- R4: `video_we` is 1 for slot indices 0 to 10 and 0 for indices 11 and 12, so U data is never written as video.
- R5: `u_we` is 1 only at slot index 11 and `v_we` only at slot index 12. Exactly one of `video_we`, `u_we` and `v_we` is high in every cycle.
- R6: A `line_start` pulse seen at a clock edge advances `line_idx` by one, modulo 13. In the next cycle `slot_idx` equals the new `line_idx`, so line k starts at slot k.
- R7: A `field_start` pulse seen at a clock edge sets both `slot_idx` and `line_idx` to 0 in the next cycle. It wins over a `line_start` pulse seen at the same edge.
- R8: `scph_en` is 1 exactly when the slot index is 12 and `line_idx` is 0.
- R9: Thirteen `line_start` pulses after a field start bring `line_idx` back to 0, and that line starts at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| slot_code | output | 2 | Type of the current slot: 00 video, 01 chroma U, 10 chroma V |
| video_we | output | 1 | Video memory write strobe |
| u_we | output | 1 | Chroma U store write strobe |
| v_we | output | 1 | Chroma V store write strobe |
| scph_en | output | 1 | Subcarrier-phase sample strobe |
| slot_idx | output | 4 | Current position in the 13-slot cycle |
| line_idx | output | 4 | Current line within the 13-line cycle |

## Verification
A directed run drives fixed-length lines of 17 samples through a full 13-line cycle. This shows that each line starts one slot further on, and that the cycle returns to slot 0 on the fourteenth line. Corner cases include a line start that lands on the U slot or the V slot, and a line start and field start that arrive together. These separate the rule for which strobe wins from the plain wrap logic. A long seeded random run uses uneven line lengths and occasional field starts. It compares every output on every cycle against a bench model, which catches decode errors that appear only on particular lines, such as a misplaced phase strobe.

// File: rtl/ilv_slot_pkg.sv
package ilv_slot_pkg;
  localparam int unsigned VIDEO_SLOTS  = 11;
  localparam int unsigned CHROMA_SLOTS = 2;
  localparam int unsigned PATTERN_LEN  = VIDEO_SLOTS + CHROMA_SLOTS;
  localparam int unsigned IDX_W        = $clog2(PATTERN_LEN);

  typedef enum logic [1:0] {
    SLOT_VID = 2'b00,
    SLOT_U   = 2'b01,
    SLOT_V   = 2'b10
  } slot_kind_e;
endpackage

// File: rtl/ilv_wrap_cnt.sv
module ilv_wrap_cnt #(
  parameter int unsigned MOD = 13,
  localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] nxt
);
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  always_comb begin
    if (cnt == LAST) nxt = '0;
    else             nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= nxt;
  end

  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && inc && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && inc && cnt == LAST) |=> (cnt == '0));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/ilv_slot_dec.sv
module ilv_slot_dec
  import ilv_slot_pkg::*;
#(
  parameter int unsigned NVID = VIDEO_SLOTS,
  localparam int unsigned LEN = NVID + CHROMA_SLOTS,
  localparam int unsigned W   = $clog2(LEN)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] slot,
  input  logic [W-1:0] line,
  output slot_kind_e   kind,
  output logic         vid_we,
  output logic         u_we,
  output logic         v_we,
  output logic         ph_en
);
  localparam logic [W-1:0] U_POS = W'(NVID);
  localparam logic [W-1:0] V_POS = W'(NVID + 1);

  always_comb begin
    kind = SLOT_VID;
    if (slot == U_POS)      kind = SLOT_U;
    else if (slot == V_POS) kind = SLOT_V;
  end

  always_comb begin
    vid_we = (kind == SLOT_VID);
    u_we   = (kind == SLOT_U);
    v_we   = (kind == SLOT_V);
    ph_en  = (kind == SLOT_V) && (line == '0);
  end

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({vid_we, u_we, v_we}));
  p_no_video_on_chroma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot >= U_POS) |-> !vid_we);
  p_phase_on_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ph_en |-> (v_we && line == '0));
endmodule

// File: rtl/ilv_slot_seq.sv
module ilv_slot_seq
  import ilv_slot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             field_start,
  output logic [1:0]       slot_code,
  output logic             video_we,
  output logic             u_we,
  output logic             v_we,
  output logic             scph_en,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] line_idx
);
  logic [IDX_W-1:0] line_nxt;
  logic [IDX_W-1:0] slot_nxt_unused;
  slot_kind_e       kind;

  // Line phase: cleared per field, stepped per line.
  ilv_wrap_cnt #(.MOD(PATTERN_LEN)) u_line_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (field_start),
    .ld     (1'b0),
    .ld_val ('0),
    .inc    (line_start),
    .cnt    (line_idx),
    .nxt    (line_nxt)
  );

  // Slot phase: free-running, reloaded with the next line phase.
  ilv_wrap_cnt #(.MOD(PATTERN_LEN)) u_slot_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (field_start),
    .ld     (line_start),
    .ld_val (line_nxt),
    .inc    (1'b1),
    .cnt    (slot_idx),
    .nxt    (slot_nxt_unused)
  );

  ilv_slot_dec #(.NVID(VIDEO_SLOTS)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot   (slot_idx),
    .line   (line_idx),
    .kind   (kind),
    .vid_we (video_we),
    .u_we   (u_we),
    .v_we   (v_we),
    .ph_en  (scph_en)
  );

  assign slot_code = kind;

  p_line_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !field_start) |=> (slot_idx == line_idx));
  p_field_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (slot_idx == '0 && line_idx == '0));
endmodule

// File: tb/ilv_slot_seq_tb_top.sv
module ilv_slot_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic field_start = 1'b0;
  logic [1:0] slot_code;
  logic video_we, u_we, v_we, scph_en;
  logic [3:0] slot_idx, line_idx;

  int n_tests = 0;
  int n_fail  = 0;
  int m_slot  = 0;
  int m_line  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  ilv_slot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .slot_code(slot_code), .video_we(video_we), .u_we(u_we), .v_we(v_we),
    .scph_en(scph_en), .slot_idx(slot_idx), .line_idx(line_idx)
  );

  // Reference model written from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot <= 0; m_line <= 0;
    end else if (field_start) begin
      m_slot <= 0; m_line <= 0;
    end else if (line_start) begin
      m_line <= (m_line + 1) % 13;
      m_slot <= (m_line + 1) % 13;
    end else begin
      m_slot <= (m_slot + 1) % 13;
    end
  end

  function automatic int exp_code(int s);
    return (s == 11) ? 1 : (s == 12) ? 2 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R6 slot_idx", slot_idx, m_slot);
    chk("R6 line_idx", line_idx, m_line);
    chk("R3 slot_code", slot_code, exp_code(m_slot));
    chk("R4 video_we", video_we, (m_slot < 11) ? 1 : 0);
    chk("R5 u_we", u_we, (m_slot == 11) ? 1 : 0);
    chk("R5 v_we", v_we, (m_slot == 12) ? 1 : 0);
    chk("R8 scph_en", scph_en, (m_slot == 12 && m_line == 0) ? 1 : 0);
  endtask

  task automatic step(input bit ls, input bit fs);
    line_start = ls; field_start = fs;
    @(negedge clk);
    line_start = 1'b0; field_start = 1'b0;
    check_all();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values while held
    chk("R1 slot_idx", slot_idx, 0);
    chk("R1 line_idx", line_idx, 0);
    chk("R1 video_we", video_we, 1);
    chk("R1 strobes", {u_we, v_we, scph_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R9: thirteen fixed-length lines after a field start
    step(1'b0, 1'b1);
    chk("R7 field cleared slot", slot_idx, 0);
    for (int ln = 1; ln <= 13; ln++) begin
      repeat (16) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      chk("R6 line start slot", slot_idx, ln % 13);
    end
    chk("R9 cycle back slot", slot_idx, 0);
    chk("R9 cycle back line", line_idx, 0);

    // R6: line start arriving on the U slot and on the V slot
    while (slot_idx != 11) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    while (slot_idx != 12) step(1'b0, 1'b0);
    step(1'b1, 1'b0);

    // R7: field and line start together
    repeat (5) step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R7 field wins slot", slot_idx, 0);
    chk("R7 field wins line", line_idx, 0);

    // Random line lengths and occasional field starts
    for (int i = 0; i < 6000; i++) begin
      bit ls, fs;
      ls = ($urandom_range(0, 29) == 0);
      fs = ($urandom_range(0, 799) == 0);
      step(ls, fs);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule